// File: doc/BRIEF.md
# Temperature Conversion Scheduler

This block decides when a temperature conversion runs and owns the stored reading. It drives an abstract converter through a one-cycle start pulse, and it accepts a one-cycle done pulse with a 16-bit two's-complement result. When the block is in normal mode, it launches conversions on a fixed period counted in clock ticks. When it is asleep, it launches nothing until the host pulses the one-shot trigger. The host drives that trigger through a write to the one-shot location of the register interface. Each trigger wakes the block for exactly one conversion, and the block then goes back to sleep.

The block also holds the 8-bit configuration register. Bit 0 requests shutdown and bit 5 selects one-shot operation. Bits 1 to 4 are stored for the alert logic. The stored reading changes only when a conversion completes, so a read in the middle of a conversion returns the previous value. Each completed conversion also produces a one-cycle sample-valid strobe, which tells the alert comparator that a fresh value is present. A status output stands in for the power gate.

Top module: `conv_scheduler`

## Requirements
- R1: After reset the block is in normal mode with the following values: tempResult reads 0x0000, cfgRdData reads 0x00, sampleValid is low and powered is high.
- R2: In normal mode (config bits 0 and 5 both 0), convStart is a one-cycle pulse, and consecutive pulses are exactly PERIOD_TICKS cycles apart.
- R3: tempResult changes only when a conversion completes. It then takes the converter result with bits 3:0 forced to 0. During a conversion that is in flight, it keeps the previous value.
- R4: sampleValid is high for exactly one cycle per completed conversion, including one-shot conversions. That cycle is the first one in which tempResult shows the new value.
- R5: Writing config bit 0 = 1 stops convStart from the cycle after the write. Once any conversion in flight has ended, no further pulses occur, tempResult holds its value and powered is low.
- R6: If shutdown is written while a conversion is in flight, that conversion still completes. Its result is stored and strobed, and then the block halts.
- R7: Writing config bit 5 = 1 puts the block into the sleeping state at once. It then issues no periodic convStart and powered is low.
- R8: While asleep (bit 0 or bit 5 set), a oneShotPulse produces exactly one convStart in the next cycle. powered stays high from that cycle until the result is stored, and afterwards the block returns to powered low with no further conversions.
- R9: A oneShotPulse that arrives while a conversion is in flight is dropped. It is not queued.
- R10: Config bits 7:6 always read as 0. Bits 5:0 read back as written.
- R11: Clearing bits 0 and 5 resumes periodic conversions, and their spacing is again PERIOD_TICKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write value |
| cfgRdData | output | 8 | Stored configuration (bits 7:6 zero) |
| oneShotPulse | input | 1 | One-cycle pulse from a write to the one-shot location |
| convStart | output | 1 | One-cycle start pulse to the converter |
| convDone | input | 1 | One-cycle completion pulse from the converter |
| convResult | input | 16 | Converter result, valid with convDone |
| tempResult | output | 16 | Stored temperature reading |
| sampleValid | output | 1 | One-cycle strobe marking a new reading for the alert logic |
| powered | output | 1 | High while the converter would be powered |

## Verification
The main function is first tried with the block running free in normal mode, to measure the exact start spacing and to show that the reading holds steady while a conversion is in flight. The same patterns are then repeated from the sleeping state. A lone one-shot trigger confirms that the block wakes for one conversion only. A second trigger during that conversion shows that triggers are dropped rather than queued. A shutdown written just after a start shows that an in-flight conversion still finishes. The converter stub returns results with nonzero low nibbles, which confirms that the stored reading has those bits cleared. Writes with the reserved bits set show that those bits read back as zero.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic captureEn;  // store converter result, raise sample strobe
    logic cfgLoad;    // load configuration register
  } schedStrobe_t;

  localparam int SHUTDOWN_BIT = 0;
  localparam int ONESHOT_BIT  = 5;

endpackage

// File: rtl/conv_sched_ctrl.sv
module conv_sched_ctrl
  import conv_sched_pkg::*;
#(
  parameter int PERIOD_TICKS = 10_000_000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic         cfgShutdown,
  input  logic         cfgOneShot,
  input  logic         oneShotPulse,
  input  logic         convDone,
  output logic         convStart,
  output logic         powered,
  output schedStrobe_t strobe
);

  localparam int CNT_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD_TICKS - 1);

  logic [CNT_W-1:0] periodCnt;
  logic             tickHit;
  logic             sleepMode;
  logic             busy;
  logic             startNow;

  // Free-running period counter; phase is kept across sleep
  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCnt <= '0;
    end else if (periodCnt == CNT_LAST) begin
      periodCnt <= '0;
    end else begin
      periodCnt <= periodCnt + 1'b1;
    end
  end

  assign tickHit   = (periodCnt == '0);
  assign sleepMode = cfgShutdown | cfgOneShot;

  // A new conversion only when none is in flight; triggers while busy are dropped
  assign startNow = !busy && (sleepMode ? oneShotPulse : tickHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      convStart <= 1'b0;
    end else begin
      convStart <= startNow;
      if (startNow) begin
        busy <= 1'b1;
      end else if (convDone) begin
        busy <= 1'b0;
      end
    end
  end

  assign powered          = !sleepMode || busy;
  assign strobe.captureEn = convDone && busy;
  assign strobe.cfgLoad   = cfgWrEn;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R2

  AST_SLEEP_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sleepMode) && !$past(oneShotPulse)) |-> !convStart); // R5

  AST_BUSY_DROPS_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && oneShotPulse) |=> !convStart); // R9

  AST_POWER_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> powered); // R8

endmodule

// File: rtl/conv_sched_dp.sv
module conv_sched_dp
  import conv_sched_pkg::*;
#(
  parameter int RES_W   = 16,
  parameter int LSB_PAD = 4,
  parameter int CFG_W   = 8,
  parameter int RSVD_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  schedStrobe_t     strobe,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic [RES_W-1:0] convResult,
  output logic [CFG_W-1:0] cfgRdData,
  output logic [RES_W-1:0] tempResult,
  output logic             sampleValid,
  output logic             cfgShutdown,
  output logic             cfgOneShot
);

  localparam int KEEP_W = CFG_W - RSVD_W;
  localparam int HIGH_W = RES_W - LSB_PAD;
  localparam logic [CFG_W-1:0] CFG_MASK = {{RSVD_W{1'b0}}, {KEEP_W{1'b1}}};
  localparam logic [RES_W-1:0] RES_MASK = {{HIGH_W{1'b1}}, {LSB_PAD{1'b0}}};

  logic [CFG_W-1:0] cfgReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (strobe.cfgLoad) begin
      cfgReg <= cfgWrData & CFG_MASK;
    end
  end

  // Reading is replaced whole, only at conversion end
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tempResult  <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobe.captureEn;
      if (strobe.captureEn) begin
        tempResult <= convResult & RES_MASK;
      end
    end
  end

  assign cfgRdData   = cfgReg;
  assign cfgShutdown = cfgReg[SHUTDOWN_BIT];
  assign cfgOneShot  = cfgReg[ONESHOT_BIT];

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable(tempResult)); // R3

  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid); // R4

endmodule

// File: rtl/conv_scheduler.sv
module conv_scheduler
  import conv_sched_pkg::*;
#(
  parameter int PERIOD_TICKS = 10_000_000,
  parameter int RES_W        = 16,
  parameter int LSB_PAD      = 4,
  parameter int CFG_W        = 8,
  parameter int RSVD_W       = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic             oneShotPulse,
  output logic             convStart,
  input  logic             convDone,
  input  logic [RES_W-1:0] convResult,
  output logic [RES_W-1:0] tempResult,
  output logic             sampleValid,
  output logic             powered
);

  schedStrobe_t strobe;
  logic         cfgShutdown;
  logic         cfgOneShot;

  conv_sched_ctrl #(
    .PERIOD_TICKS(PERIOD_TICKS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWrEn     (cfgWrEn),
    .cfgShutdown (cfgShutdown),
    .cfgOneShot  (cfgOneShot),
    .oneShotPulse(oneShotPulse),
    .convDone    (convDone),
    .convStart   (convStart),
    .powered     (powered),
    .strobe      (strobe)
  );

  conv_sched_dp #(
    .RES_W  (RES_W),
    .LSB_PAD(LSB_PAD),
    .CFG_W  (CFG_W),
    .RSVD_W (RSVD_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgWrData  (cfgWrData),
    .convResult (convResult),
    .cfgRdData  (cfgRdData),
    .tempResult (tempResult),
    .sampleValid(sampleValid),
    .cfgShutdown(cfgShutdown),
    .cfgOneShot (cfgOneShot)
  );

endmodule

// File: tb/conv_scheduler_bench.sv
`timescale 1ns/1ps
module conv_scheduler_bench;

  localparam int PERIOD = 40;
  localparam int LAT    = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrData = 8'h00;
  logic [7:0]  cfgRdData;
  logic        oneShotPulse = 1'b0;
  logic        convStart;
  logic        convDone = 1'b0;
  logic [15:0] convResult = 16'h0000;
  logic [15:0] tempResult;
  logic        sampleValid;
  logic        powered;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  conv_scheduler #(.PERIOD_TICKS(PERIOD)) u_conv_scheduler (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .oneShotPulse(oneShotPulse), .convStart(convStart),
    .convDone(convDone), .convResult(convResult), .tempResult(tempResult),
    .sampleValid(sampleValid), .powered(powered)
  );

  // Converter stub and event counters, all updated at the falling edge
  int cyc = 0;
  int cnt = 0;
  int convIdx = 0;
  int startCount = 0;
  int sampleCount = 0;
  int lastStartCyc = 0;
  int lastInterval = 0;
  logic [15:0] lastDoneVal = 16'h0000;

  always @(posedge clk) cyc = cyc + 1;

  always @(negedge clk) begin
    convDone = 1'b0;
    if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        convIdx = convIdx + 1;
        convResult = 16'h1235 + 16'(convIdx * 3863);
        lastDoneVal = convResult;
        convDone = 1'b1;
      end
    end
    if (convStart) begin
      startCount = startCount + 1;
      lastInterval = cyc - lastStartCyc;
      lastStartCyc = cyc;
      cnt = LAT;
    end
    if (sampleValid) sampleCount = sampleCount + 1;
  end

  task automatic checkEq(string tag, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic writeCfg(logic [7:0] d);
    cfgWrData = d;
    cfgWrEn = 1'b1;
    tick(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic pulseShot();
    oneShotPulse = 1'b1;
    tick(1);
    oneShotPulse = 1'b0;
  endtask

  task automatic waitStart(string tag);
    int base = startCount;
    int lim = 0;
    while (startCount == base && lim < 1000) begin
      tick(1);
      lim++;
    end
    if (startCount == base) checkEq({tag, " start timeout"}, 0, 1);
  endtask

  task automatic waitSample(string tag);
    int base = sampleCount;
    int lim = 0;
    while (sampleCount == base && lim < 1000) begin
      tick(1);
      lim++;
    end
    if (sampleCount == base) checkEq({tag, " sample timeout"}, 0, 1);
  endtask

  function automatic int masked();
    return int'(lastDoneVal & 16'hFFF0);
  endfunction

  task automatic testReset();
    tick(1);
    checkEq("R1 tempResult", int'(tempResult), 0);
    checkEq("R1 cfgRdData", int'(cfgRdData), 0);
    checkEq("R1 sampleValid", int'(sampleValid), 0);
    checkEq("R1 powered", int'(powered), 1);
  endtask

  task automatic testPeriodic();
    waitStart("R2");
    for (int k = 0; k < 3; k++) begin
      int prev;
      waitStart("R2");
      checkEq("R2 start interval", lastInterval, PERIOD);
      prev = masked();
      tick(3);
      checkEq("R3 hold during conversion", int'(tempResult), prev);
      waitSample("R4");
      checkEq("R4 strobe with new value", int'(sampleValid), 1);
      checkEq("R3 stored masked result", int'(tempResult), masked());
      tick(1);
      checkEq("R4 strobe one cycle", int'(sampleValid), 0);
    end
  endtask

  task automatic testShutdown();
    int base;
    int lim = 0;
    writeCfg(8'hC1);
    checkEq("R10 reserved bits zero", int'(cfgRdData), 8'h01);
    while (powered && lim < 200) begin tick(1); lim++; end
    base = startCount;
    tick(3 * PERIOD);
    checkEq("R5 no starts in shutdown", startCount, base);
    checkEq("R5 result held", int'(tempResult), masked());
    checkEq("R5 powered low", int'(powered), 0);
  endtask

  task automatic testOneShot();
    int bs = startCount;
    int bv = sampleCount;
    pulseShot();
    checkEq("R8 one start", startCount, bs + 1);
    checkEq("R8 powered during shot", int'(powered), 1);
    waitSample("R8");
    checkEq("R8 result stored", int'(tempResult), masked());
    tick(1);
    checkEq("R8 back to powered low", int'(powered), 0);
    tick(3 * PERIOD);
    checkEq("R8 single start only", startCount, bs + 1);
    checkEq("R4 one strobe for shot", sampleCount, bv + 1);
  endtask

  task automatic testShotWhileBusy();
    int bs = startCount;
    int bv = sampleCount;
    pulseShot();
    tick(4);
    pulseShot();
    tick(LAT + 3 * PERIOD);
    checkEq("R9 second trigger dropped", startCount, bs + 1);
    checkEq("R9 one sample", sampleCount, bv + 1);
  endtask

  task automatic testMidShutdown();
    int bv;
    int bs;
    writeCfg(8'h00);
    waitStart("R6");
    bv = sampleCount;
    tick(2);
    writeCfg(8'h01);
    checkEq("R6 powered while finishing", int'(powered), 1);
    tick(LAT + 2);
    checkEq("R6 conversion completed", sampleCount, bv + 1);
    checkEq("R6 result stored", int'(tempResult), masked());
    bs = startCount;
    tick(3 * PERIOD);
    checkEq("R6 halted after finish", startCount, bs);
    checkEq("R6 powered low", int'(powered), 0);
  endtask

  task automatic testOneShotMode();
    int bs;
    writeCfg(8'h00);
    waitStart("R7");
    waitSample("R7");
    writeCfg(8'h20);
    checkEq("R7 asleep at once", int'(powered), 0);
    checkEq("R10 bit5 readback", int'(cfgRdData), 8'h20);
    bs = startCount;
    tick(3 * PERIOD);
    checkEq("R7 no periodic starts", startCount, bs);
    pulseShot();
    checkEq("R7 shot starts conversion", startCount, bs + 1);
    waitSample("R7");
    checkEq("R7 shot result", int'(tempResult), masked());
  endtask

  task automatic testResume();
    tick(2);
    writeCfg(8'h00);
    waitStart("R11");
    waitStart("R11");
    checkEq("R11 periodic spacing", lastInterval, PERIOD);
    checkEq("R11 powered", int'(powered), 1);
  endtask

  initial begin
    tick(5);
    rstN = 1'b1;
    testReset();
    testPeriodic();
    testShutdown();
    testOneShot();
    testShotWhileBusy();
    testMidShutdown();
    testOneShotMode();
    testResume();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule